// File: doc/BRIEF.md
# Band-Selectable Synthesizer Feedback Divider

This block is the digital feedback divider of an integer-N frequency synthesizer. The fast oscillator clock drives a first counter. The output of that counter is brought out as the second local-oscillator signal, and it also advances a second counter. The output of the second counter is the comparison clock for the phase-frequency detector. A band-select input chooses which pair of ratios the two counters use. The first counter divides by 4 and the second by 6 in the low band. The first divides by 2 and the second by 12 in the high band. The product is 24 in both bands, so the comparison clock keeps the same frequency when the band changes.

A second, independent path divides the crystal reference clock by eight to make a clock for a microcontroller. This output runs only while its enable input is high. The enable stands in for an external load being present. When it is low, the output sits low. Both clock domains have an asynchronous active-low reset. Each domain releases that reset synchronously with its own clock.

Both counters run on the oscillator clock and use clock enables, so no logic is clocked by a derived clock. A change of band is synchronised into the oscillator domain and held back. It takes effect only at the end of a full comparison period. At that point both counters wrap together, so the comparison clock never shows a shortened phase.

Top module: `fb_div_chain`

## Requirements
- R1: With the applied band low, `lo2_clk` is high for 2 and low for 2 `vco_clk` cycles, which is a division by 4.
- R2: With the applied band high, `lo2_clk` changes level on every `vco_clk` cycle, which is a division by 2.
- R3: Once running, every high phase and every low phase of `cmp_clk` lasts exactly 12 `vco_clk` cycles in either band. This also holds across a band change, so the total division is 24.
- R4: The internal count of each stage stays below that stage's half-ratio, so every stage has a 50% duty cycle.
- R5: A new `band_sel` level (0 = low band, 1 = high band) is applied only at a falling edge of `cmp_clk`. The `lo2_clk` phases keep the previous ratio until that edge. After any reset the chain starts in the low band.
- R6: Every level change of `cmp_clk` happens in the same cycle as a rising edge of `lo2_clk`.
- R7: While `mcu_clk_en` is held high, `mcu_clk` is high for 4 and low for 4 `ref_clk` cycles, which is the reference divided by 8.
- R8: `mcu_clk` starts a pulse only while the synchronised enable is high, and every pulse lasts a full 4 cycles. Within 10 `ref_clk` cycles of `mcu_clk_en` going low, `mcu_clk` stays low.
- R9: While `rst_n` is low, `lo2_clk`, `cmp_clk` and `mcu_clk` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast oscillator clock that drives the divider chain |
| ref_clk | input | 1 | Crystal reference clock for the microcontroller clock path |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| band_sel | input | 1 | Band request: 0 = low band (4 x 6), 1 = high band (2 x 12); asynchronous |
| mcu_clk_en | input | 1 | Enables the microcontroller clock; asynchronous |
| lo2_clk | output | 1 | Output of the first counter, used as the second local oscillator |
| cmp_clk | output | 1 | Output of the second counter, used as the phase-detector comparison clock |
| mcu_clk | output | 1 | Reference clock divided by 8, gated by the enable |

## Verification
The hardest case to reach from the ports is a band request that settles shortly before the end of a comparison period. The ratios must then swap exactly at the falling edge of `cmp_clk`, with the last old-width `lo2_clk` phase completed and no short `cmp_clk` phase. The stimulus therefore waits for a rising edge of `cmp_clk`. It then changes `band_sel` after a random offset of 0 to 6 cycles, which still lets the request pass the synchroniser in time. The bench tracks which band is applied by updating its own model at each observed falling edge. It checks every `lo2_clk` and `cmp_clk` phase length against that model. A reset is also applied mid-run while the high band is requested, to show that the chain restarts in the low band.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  typedef enum logic {
    BAND_LOW  = 1'b0,
    BAND_HIGH = 1'b1
  } band_e;

  function automatic int half_of(input int ratio);
    return ratio / 2;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fbdiv_rst_sync.sv
module fbdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/fbdiv_bit_sync.sv
module fbdiv_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/fbdiv_ratio_stage.sv
module fbdiv_ratio_stage #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] half,
  output logic          toggle,
  output logic          div_out
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          out_d;

  always_comb begin
    toggle = en && (cnt_q == (half - CW'(1)));
    cnt_d  = cnt_q;
    out_d  = div_out;
    if (en) begin
      if (toggle) begin
        cnt_d = '0;
        out_d = ~div_out;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      div_out <= out_d;
    end
  end

  // R4: the count never reaches the half-ratio, including right after a ratio swap
  assert_cnt_below_half_R4: assert property (
    @(posedge clk) disable iff (!rst_n) cnt_q < half
  );

endmodule

// File: rtl/fbdiv_band_ctrl.sv
module fbdiv_band_ctrl
  import fbdiv_pkg::*;
#(
  parameter int CW    = 3,
  parameter int N1_LO = 4,
  parameter int N2_LO = 6,
  parameter int N1_HI = 2,
  parameter int N2_HI = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          band_req,
  input  logic          reload,
  input  logic          cmp_level,
  output logic [CW-1:0] half1,
  output logic [CW-1:0] half2
);

  logic  band_s;
  band_e band_q;
  band_e band_d;

  fbdiv_bit_sync #(.STAGES(2)) u_band_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (band_req),
    .dout  (band_s)
  );

  always_comb begin
    band_d = band_q;
    if (reload) band_d = band_e'(band_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) band_q <= BAND_LOW;
    else        band_q <= band_d;
  end

  always_comb begin
    if (band_q == BAND_HIGH) begin
      half1 = CW'(half_of(N1_HI));
      half2 = CW'(half_of(N2_HI));
    end else begin
      half1 = CW'(half_of(N1_LO));
      half2 = CW'(half_of(N2_LO));
    end
  end

  // R5: the applied band only moves on a falling edge of the comparison clock
  assert_band_swap_on_fall_R5: assert property (
    @(posedge clk) disable iff (!rst_n) !$stable(band_q) |-> $fell(cmp_level)
  );

endmodule

// File: rtl/fb_div_chain.sv
module fb_div_chain
  import fbdiv_pkg::*;
#(
  parameter int N1_LO   = 4,
  parameter int N2_LO   = 6,
  parameter int N1_HI   = 2,
  parameter int N2_HI   = 12,
  parameter int REF_DIV = 8
) (
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic band_sel,
  input  logic mcu_clk_en,
  output logic lo2_clk,
  output logic cmp_clk,
  output logic mcu_clk
);

  localparam int MAX_HALF = max2(max2(half_of(N1_LO), half_of(N2_LO)),
                                 max2(half_of(N1_HI), half_of(N2_HI)));
  localparam int CW       = $clog2(MAX_HALF + 1);
  localparam int HALF_CMP = (N1_LO * N2_LO) / 2;
  localparam int GW       = $clog2(HALF_CMP + 2) + 1;
  localparam int REF_HALF = half_of(REF_DIV);
  localparam int RCW      = $clog2(REF_HALF + 1);

  // ---------------- oscillator domain ----------------
  logic          vrst_n;
  logic [CW-1:0] half1;
  logic [CW-1:0] half2;
  logic          s1_toggle;
  logic          s2_toggle;
  logic          s2_en;
  logic          reload;

  fbdiv_rst_sync #(.STAGES(2)) u_vco_rst (
    .clk    (vco_clk),
    .arst_n (rst_n),
    .srst_n (vrst_n)
  );

  fbdiv_band_ctrl #(
    .CW    (CW),
    .N1_LO (N1_LO),
    .N2_LO (N2_LO),
    .N1_HI (N1_HI),
    .N2_HI (N2_HI)
  ) u_band (
    .clk       (vco_clk),
    .rst_n     (vrst_n),
    .band_req  (band_sel),
    .reload    (reload),
    .cmp_level (cmp_clk),
    .half1     (half1),
    .half2     (half2)
  );

  fbdiv_ratio_stage #(.CW(CW)) u_stage1 (
    .clk     (vco_clk),
    .rst_n   (vrst_n),
    .en      (1'b1),
    .half    (half1),
    .toggle  (s1_toggle),
    .div_out (lo2_clk)
  );

  always_comb begin
    s2_en  = s1_toggle && !lo2_clk;
    reload = s2_toggle && cmp_clk;
  end

  fbdiv_ratio_stage #(.CW(CW)) u_stage2 (
    .clk     (vco_clk),
    .rst_n   (vrst_n),
    .en      (s2_en),
    .half    (half2),
    .toggle  (s2_toggle),
    .div_out (cmp_clk)
  );

  // ---------------- reference domain ----------------
  logic           rrst_n;
  logic           en_s;
  logic           r_toggle;
  logic           r_div;
  logic           mcu_d;
  logic [RCW-1:0] ref_half;

  assign ref_half = RCW'(REF_HALF);

  fbdiv_rst_sync #(.STAGES(2)) u_ref_rst (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (rrst_n)
  );

  fbdiv_bit_sync #(.STAGES(2)) u_en_sync (
    .clk   (ref_clk),
    .rst_n (rrst_n),
    .din   (mcu_clk_en),
    .dout  (en_s)
  );

  fbdiv_ratio_stage #(.CW(RCW)) u_ref_div (
    .clk     (ref_clk),
    .rst_n   (rrst_n),
    .en      (1'b1),
    .half    (ref_half),
    .toggle  (r_toggle),
    .div_out (r_div)
  );

  always_comb begin
    mcu_d = mcu_clk;
    if (r_toggle) begin
      if (!r_div) mcu_d = en_s;
      else        mcu_d = 1'b0;
    end
  end

  always_ff @(posedge ref_clk or negedge rrst_n) begin
    if (!rrst_n) mcu_clk <= 1'b0;
    else         mcu_clk <= mcu_d;
  end

  // R8: a pulse may only start while the synchronised enable is high
  assert_mcu_rise_needs_en_R8: assert property (
    @(posedge ref_clk) disable iff (!rrst_n) $rose(mcu_clk) |-> $past(en_s)
  );

  // ---------------- checker state for comparison phase length ----------------
  logic          cmp_d;
  logic          gap_armed;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge vco_clk or negedge vrst_n) begin
    if (!vrst_n) begin
      cmp_d     <= 1'b0;
      gap_armed <= 1'b0;
      gap_cnt   <= '0;
    end else begin
      cmp_d <= cmp_clk;
      if (cmp_clk != cmp_d) begin
        gap_cnt   <= '0;
        gap_armed <= 1'b1;
      end else if (gap_cnt != {GW{1'b1}}) begin
        gap_cnt <= gap_cnt + GW'(1);
      end
    end
  end

  // R3: each comparison phase lasts the same number of oscillator cycles in both bands
  assert_cmp_phase_len_R3: assert property (
    @(posedge vco_clk) disable iff (!vrst_n)
      ($changed(cmp_clk) && gap_armed) |-> (gap_cnt == GW'(HALF_CMP - 1))
  );

  // R6: comparison edges line up with rising edges of the first stage output
  assert_cmp_on_lo2_rise_R6: assert property (
    @(posedge vco_clk) disable iff (!vrst_n) $changed(cmp_clk) |-> $rose(lo2_clk)
  );

endmodule

// File: tb/fb_div_chain_test.sv
module fb_div_chain_test;

  logic vco_clk;
  logic ref_clk;
  logic rst_n;
  logic band_sel;
  logic mcu_clk_en;
  logic lo2_clk;
  logic cmp_clk;
  logic mcu_clk;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;
  bit mon_on;

  fb_div_chain uut (
    .vco_clk    (vco_clk),
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .band_sel   (band_sel),
    .mcu_clk_en (mcu_clk_en),
    .lo2_clk    (lo2_clk),
    .cmp_clk    (cmp_clk),
    .mcu_clk    (mcu_clk)
  );

  initial begin
    vco_clk = 1'b0;
    forever #2 vco_clk = ~vco_clk;
  end

  initial begin
    ref_clk = 1'b0;
    forever #7 ref_clk = ~ref_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected half-periods taken from the requirements
  function automatic int exp_lo2_half(input bit band);
    return band ? 1 : 2;
  endfunction

  function automatic int exp_cmp_half();
    return 12;
  endfunction

  // ---------------- oscillator-domain monitor ----------------
  bit lo2_prev, cmp_prev, lo2_seen, cmp_seen, eff_band;
  int lo2_len, cmp_len, swap_win;

  always @(negedge vco_clk) begin
    if (!mon_on) begin
      lo2_prev = lo2_clk;
      cmp_prev = cmp_clk;
      lo2_seen = 1'b0;
      cmp_seen = 1'b0;
      eff_band = 1'b0;
      lo2_len  = 0;
      cmp_len  = 0;
      swap_win = 0;
    end else begin
      lo2_len++;
      cmp_len++;
      if (lo2_clk != lo2_prev) begin
        if (lo2_seen) begin
          if (swap_win > 0)
            chk(lo2_len == exp_lo2_half(eff_band), "R5", lo2_len, exp_lo2_half(eff_band));
          else if (eff_band)
            chk(lo2_len == exp_lo2_half(eff_band), "R2", lo2_len, exp_lo2_half(eff_band));
          else
            chk(lo2_len == exp_lo2_half(eff_band), "R1", lo2_len, exp_lo2_half(eff_band));
          if (swap_win > 0) swap_win--;
        end
        lo2_seen = 1'b1;
        lo2_len  = 0;
      end
      if (cmp_clk != cmp_prev) begin
        chk(lo2_clk && !lo2_prev, "R6", int'(lo2_clk), 1);
        if (cmp_seen) chk(cmp_len == exp_cmp_half(), "R3", cmp_len, exp_cmp_half());
        cmp_seen = 1'b1;
        cmp_len  = 0;
        if (!cmp_clk) begin
          if (eff_band != band_sel) swap_win = 3;
          eff_band = band_sel;
        end
      end
      lo2_prev = lo2_clk;
      cmp_prev = cmp_clk;
    end
  end

  // ---------------- reference-domain monitor ----------------
  bit mcu_prev, mcu_seen;
  int mcu_len, en_hi_cnt, en_lo_cnt;

  always @(negedge ref_clk) begin
    if (!mon_on) begin
      mcu_prev  = mcu_clk;
      mcu_seen  = 1'b0;
      mcu_len   = 0;
      en_hi_cnt = 0;
      en_lo_cnt = 0;
    end else begin
      if (mcu_clk_en) begin en_hi_cnt++; en_lo_cnt = 0; end
      else            begin en_lo_cnt++; en_hi_cnt = 0; end
      mcu_len++;
      if (mcu_clk != mcu_prev) begin
        if (mcu_seen) begin
          if (mcu_prev)
            chk(mcu_len == 4, "R7", mcu_len, 4);
          else if (en_hi_cnt >= 16)
            chk(mcu_len == 4, "R7", mcu_len, 4);
        end
        mcu_seen = 1'b1;
        mcu_len  = 0;
      end
      if (en_lo_cnt >= 10) chk(mcu_clk == 1'b0, "R8", int'(mcu_clk), 0);
      mcu_prev = mcu_clk;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge vco_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic drive_gap();
    @(negedge vco_clk);
    #1;
  endtask

  task automatic check_reset_zero();
    chk(lo2_clk == 1'b0, "R9", int'(lo2_clk), 0);
    chk(cmp_clk == 1'b0, "R9", int'(cmp_clk), 0);
    chk(mcu_clk == 1'b0, "R9", int'(mcu_clk), 0);
  endtask

  task automatic switch_band(input bit b, input int offs);
    @(posedge cmp_clk);
    for (int i = 0; i < offs; i++) @(negedge vco_clk);
    #1;
    band_sel = b;
  endtask

  task automatic run_periods(input int p);
    for (int i = 0; i < p; i++) @(posedge cmp_clk);
  endtask

  initial begin
    int seed_dummy;
    n_chk      = 0;
    n_fail     = 0;
    cyc        = 0;
    done       = 1'b0;
    mon_on     = 1'b0;
    rst_n      = 1'b0;
    band_sel   = 1'b0;
    mcu_clk_en = 1'b0;
    seed_dummy = $urandom(32'h5EED_0024);

    for (int i = 0; i < 3; i++) begin
      @(negedge vco_clk);
      check_reset_zero();
    end
    drive_gap();
    rst_n  = 1'b1;
    mon_on = 1'b1;

    // low band with the microcontroller clock disabled
    run_periods(10);
    // enable microcontroller clock, high band with immediate change after a rise
    drive_gap();
    mcu_clk_en = 1'b1;
    switch_band(1'b1, 0);
    run_periods(10);
    // back to low band with the latest safe offset
    switch_band(1'b0, 6);
    run_periods(6);

    // random band changes and enable toggling
    for (int it = 0; it < 30; it++) begin
      bit b;
      int k;
      int p;
      b = 1'($urandom() % 2);
      k = int'($urandom() % 7);
      p = 1 + int'($urandom() % 4);
      switch_band(b, k);
      if (($urandom() % 4) == 0) begin
        drive_gap();
        mcu_clk_en = ~mcu_clk_en;
      end
      run_periods(p);
    end

    // mid-run reset with the high band requested
    switch_band(1'b1, 2);
    run_periods(3);
    drive_gap();
    mon_on = 1'b0;
    rst_n  = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge ref_clk);
      check_reset_zero();
    end
    drive_gap();
    rst_n  = 1'b1;
    mon_on = 1'b1;
    run_periods(8);

    // disable the microcontroller clock and hold it off
    drive_gap();
    mcu_clk_en = 1'b0;
    run_periods(10);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule